// File: doc/BRIEF.md
# SIMD Integer Vector Compare Unit

This unit runs one integer vector-compare instruction per clock. It takes a 32-bit instruction word and two 128-bit source vectors. It decodes which predicate and lane width the word selects, compares every lane pair of the sources, and returns a 128-bit mask. In the mask, each lane is either all ones or all zeros. The unit also returns the destination register index taken from the instruction.

When an instruction asks for a recorded result, the unit also produces a 4-bit condition nibble. The nibble states whether every mask bit is one or whether every mask bit is zero. Instruction words that do not belong to the supported table are reported as illegal, and no result is produced for them. The surrounding pipeline owns the register file, operand reads and write-back. This unit only turns an instruction and its operands into a mask, flags and an exception indication, one cycle after the inputs are accepted.

Top module: `simd_cmp_unit`

## Requirements
- R1: An accepted legal instruction (in_valid high) yields out_valid high exactly one clock later, with out_dest equal to instruction bits [25:21]. A cycle with in_valid low yields out_valid, out_illegal and out_flag_valid all low one clock later.
- R2: Each result lane is all ones when the predicate holds for that lane pair and all zeros otherwise. A lane's result depends only on the source bits inside that lane.
- R3: Equality is selected by the extended opcode (instruction bits [9:0]) 0000000110, 0001000110, 0010000110 and 0011000111, for 8, 16, 32 and 64-bit lanes respectively.
- R4: Inequality is selected by extended opcodes 0000000111, 0001000111 and 0010000111, for 8, 16 and 32-bit lanes. There is no 64-bit inequality.
- R5: Unsigned greater-than (first source above second) is selected by 1000000110, 1001000110, 1010000110 and 1011000111, for 8, 16, 32 and 64-bit lanes.
- R6: Signed two's-complement greater-than is selected by 1100000110, 1101000110, 1110000110 and 1111000111, for 8, 16, 32 and 64-bit lanes.
- R7: When the record bit (instruction bit 10) is 1 on a legal instruction, out_flag_valid rises together with out_valid. In that case out_flags[3] is 1 exactly when all 128 mask bits are one, out_flags[1] is 1 exactly when all 128 mask bits are zero, and bits 2 and 0 are 0.
- R8: When the record bit is 0, out_flag_valid stays low and out_flags keeps its previous value.
- R9: A primary opcode (bits [31:26]) other than 000100, or an extended opcode outside R3 to R6, raises out_illegal one clock later. In that case out_valid and out_flag_valid are low, and out_flags is unchanged.
- R10: A synchronous active-high reset clears out_valid, out_illegal, out_flag_valid and out_flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| in_instr | input | 32 | Compare instruction word |
| in_src_a | input | 128 | First source vector (lane 0 in the most significant bits) |
| in_src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Mask and destination index are valid |
| out_mask | output | 128 | Per-lane all-ones/all-zeros compare result |
| out_dest | output | 5 | Destination register index |
| out_illegal | output | 1 | The accepted instruction was not a supported encoding |
| out_flag_valid | output | 1 | Condition nibble was updated by this result |
| out_flags | output | 4 | Condition nibble: bit 3 all true, bit 1 none true |

## Verification
A decode error that pairs a predicate with the wrong lane width shows up in out_mask on the very next cycle. It is only visible, however, when the operands differ in a way that crosses a lane boundary, so the stimulus varies single bytes and sign bits inside wide lanes. A corrupted summary register appears as a wrong out_flags value. On non-recorded or illegal instructions it appears as a nibble that changes when it should hold, and it stays visible until the next recorded result. A wrong legality decision appears one cycle after the instruction, as a swapped out_valid/out_illegal pair.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    localparam int VEC_W       = 128;
    localparam int INSTR_W     = 32;
    localparam int REG_IDX_W   = 5;
    localparam int FLAG_W      = 4;
    localparam int NUM_WIDTHS  = 4;
    localparam int BASE_LANE_W = 8;
    localparam int XO_W        = 10;

    localparam logic [5:0] PRIMARY_OP = 6'b000100;
    localparam logic [4:0] XO_FIXED   = 5'b00011;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_NE  = 2'd1,
        CMP_GTU = 2'd2,
        CMP_GTS = 2'd3
    } cmp_pred_e;

    typedef enum logic [1:0] {
        LW_8  = 2'd0,
        LW_16 = 2'd1,
        LW_32 = 2'd2,
        LW_64 = 2'd3
    } lane_w_e;

    typedef struct packed {
        logic                 legal;
        cmp_pred_e            pred;
        lane_w_e              lw;
        logic                 rec;
        logic [REG_IDX_W-1:0] dest;
    } cmp_op_t;

    // All-true in bit 3, none-true in bit 1, from the two halves of a mask.
    function automatic logic [FLAG_W-1:0] summarize(input logic [VEC_W/2-1:0] hi,
                                                    input logic [VEC_W/2-1:0] lo);
        logic all_set;
        logic none_set;
        all_set  = &(hi & lo);
        none_set = ~|(hi | lo);
        return {all_set, 1'b0, none_set, 1'b0};
    endfunction

endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
    import vcmp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output cmp_op_t            op
);

    logic [5:0]      primary;
    logic [XO_W-1:0] xo;
    logic            shape_ok;
    logic            dword;

    assign primary  = instr[31:26];
    assign xo       = instr[XO_W-1:0];
    assign shape_ok = (primary == PRIMARY_OP) && (xo[5:1] == XO_FIXED);
    assign dword    = (xo[7:6] == 2'b11);

    always_comb begin
        op       = '0;
        op.pred  = CMP_EQ;
        op.lw    = lane_w_e'(xo[7:6]);
        op.rec   = instr[10];
        op.dest  = instr[25:21];
        if (shape_ok) begin
            unique case (xo[9:8])
                2'b00: begin
                    // Low bit equal to the doubleword flag selects equality;
                    // a set low bit on a narrow lane selects inequality.
                    if (xo[0] == dword) begin
                        op.legal = 1'b1;
                        op.pred  = CMP_EQ;
                    end else if (xo[0] && !dword) begin
                        op.legal = 1'b1;
                        op.pred  = CMP_NE;
                    end
                end
                2'b10: begin
                    op.legal = (xo[0] == dword);
                    op.pred  = CMP_GTU;
                end
                2'b11: begin
                    op.legal = (xo[0] == dword);
                    op.pred  = CMP_GTS;
                end
                default: op.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/vcmp_lanes.sv
module vcmp_lanes
    import vcmp_pkg::*;
#(
    parameter int VEC_BITS = 128,
    parameter int LANE_W   = 8
) (
    input  cmp_pred_e            pred,
    input  logic [VEC_BITS-1:0]  a,
    input  logic [VEC_BITS-1:0]  b,
    output logic [VEC_BITS-1:0]  mask
);

    localparam int LANES = VEC_BITS / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane 0 sits at the most significant end of the vector.
        localparam int HI = VEC_BITS - 1 - i * LANE_W;
        logic [LANE_W-1:0] ea;
        logic [LANE_W-1:0] eb;
        logic              hit;

        assign ea = a[HI -: LANE_W];
        assign eb = b[HI -: LANE_W];

        always_comb begin
            unique case (pred)
                CMP_EQ:  hit = (ea == eb);
                CMP_NE:  hit = (ea != eb);
                CMP_GTU: hit = (ea > eb);
                CMP_GTS: hit = ($signed(ea) > $signed(eb));
                default: hit = 1'b0;
            endcase
        end

        assign mask[HI -: LANE_W] = {LANE_W{hit}};
    end

endmodule

// File: rtl/vcmp_summary.sv
module vcmp_summary
    import vcmp_pkg::*;
#(
    parameter int VEC_BITS = 128
) (
    input  logic [VEC_BITS-1:0] mask,
    output logic [FLAG_W-1:0]   flags
);

    localparam int HALF = VEC_BITS / 2;

    assign flags = summarize(mask[VEC_BITS-1:HALF], mask[HALF-1:0]);

endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
    import vcmp_pkg::*;
#(
    parameter int VEC_BITS = vcmp_pkg::VEC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   in_instr,
    input  logic [VEC_BITS-1:0]  in_src_a,
    input  logic [VEC_BITS-1:0]  in_src_b,
    output logic                 out_valid,
    output logic [VEC_BITS-1:0]  out_mask,
    output logic [REG_IDX_W-1:0] out_dest,
    output logic                 out_illegal,
    output logic                 out_flag_valid,
    output logic [FLAG_W-1:0]    out_flags
);

    cmp_op_t             op;
    logic [VEC_BITS-1:0] width_mask [NUM_WIDTHS];
    logic [VEC_BITS-1:0] sel_mask;
    logic [FLAG_W-1:0]   next_flags;
    logic                take;
    logic                take_rec;

    vcmp_decode u_decode (
        .instr (in_instr),
        .op    (op)
    );

    for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
        vcmp_lanes #(
            .VEC_BITS (VEC_BITS),
            .LANE_W   (BASE_LANE_W << w)
        ) u_lanes (
            .pred (op.pred),
            .a    (in_src_a),
            .b    (in_src_b),
            .mask (width_mask[w])
        );
    end

    assign sel_mask = width_mask[op.lw];

    vcmp_summary #(
        .VEC_BITS (VEC_BITS)
    ) u_summary (
        .mask  (sel_mask),
        .flags (next_flags)
    );

    assign take     = in_valid && op.legal;
    assign take_rec = take && op.rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_illegal    <= 1'b0;
            out_flag_valid <= 1'b0;
            out_flags      <= '0;
            out_mask       <= '0;
            out_dest       <= '0;
        end else begin
            out_valid      <= take;
            out_illegal    <= in_valid && !op.legal;
            out_flag_valid <= take_rec;
            if (take) begin
                out_mask <= sel_mask;
                out_dest <= op.dest;
            end
            if (take_rec) begin
                out_flags <= next_flags;
            end
        end
    end

endmodule

// File: rtl/simd_cmp_checker.sv
module simd_cmp_checker
    import vcmp_pkg::*;
#(
    parameter int VEC_BITS = vcmp_pkg::VEC_W
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                out_valid,
    input logic [VEC_BITS-1:0] out_mask,
    input logic                out_illegal,
    input logic                out_flag_valid,
    input logic [FLAG_W-1:0]   out_flags
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && !out_flag_valid));

    p_illegal_excl_r9: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_valid && !out_flag_valid));

    p_flag_needs_result_r7: assert property (@(posedge clk) disable iff (rst)
        out_flag_valid |-> out_valid);

    p_flag_content_r7: assert property (@(posedge clk) disable iff (rst)
        out_flag_valid |-> (out_flags[3] == (&out_mask) && out_flags[1] == (~|out_mask)
                            && !out_flags[2] && !out_flags[0]));

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !out_flag_valid |-> $stable(out_flags));

    for (genvar i = 0; i < VEC_BITS / BASE_LANE_W; i++) begin : g_byte
        p_byte_uniform_r2: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_mask[i*BASE_LANE_W +: BASE_LANE_W] == '0
                           || out_mask[i*BASE_LANE_W +: BASE_LANE_W] == '1));
    end

endmodule

bind simd_cmp_unit simd_cmp_checker #(.VEC_BITS(VEC_BITS)) i_chk (.*);

// File: tb/test_simd_cmp_unit.sv
module test_simd_cmp_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic         v;
        logic         ill;
        logic         fv;
        logic [127:0] m;
        logic [4:0]   d;
        logic [3:0]   f;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_instr = '0;
    logic [127:0] in_src_a = '0;
    logic [127:0] in_src_b = '0;
    logic         out_valid;
    logic [127:0] out_mask;
    logic [4:0]   out_dest;
    logic         out_illegal;
    logic         out_flag_valid;
    logic [3:0]   out_flags;

    exp_t         sb[$];
    int           n_cmp = 0;
    int           n_bad = 0;
    logic [3:0]   held_flags = '0;
    bit           done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_cmp_unit i_simd_cmp_unit (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_instr       (in_instr),
        .in_src_a       (in_src_a),
        .in_src_b       (in_src_b),
        .out_valid      (out_valid),
        .out_mask       (out_mask),
        .out_dest       (out_dest),
        .out_illegal    (out_illegal),
        .out_flag_valid (out_flag_valid),
        .out_flags      (out_flags)
    );

    task automatic cmp(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // pred: 0 equal, 1 not-equal, 2 unsigned greater, 3 signed greater
    function automatic logic [127:0] model(int pred, int lw, logic [127:0] a, logic [127:0] b);
        logic [127:0] m;
        m = '0;
        for (int i = 0; i < 128 / lw; i++) begin
            logic [63:0] xa;
            logic [63:0] xb;
            logic        hit;
            xa = '0;
            xb = '0;
            for (int j = 0; j < 64; j++) begin
                if (j < lw) begin
                    xa[j] = a[i*lw+j];
                    xb[j] = b[i*lw+j];
                end else if (pred == 3) begin
                    xa[j] = a[i*lw+lw-1];
                    xb[j] = b[i*lw+lw-1];
                end
            end
            case (pred)
                0:       hit = (xa == xb);
                1:       hit = (xa != xb);
                2:       hit = (xa > xb);
                default: hit = ($signed(xa) > $signed(xb));
            endcase
            for (int j = 0; j < lw; j++) m[i*lw+j] = hit;
        end
        return m;
    endfunction

    function automatic logic [9:0] xo_of(int pred, int w);
        logic [1:0] hi;
        logic       lo;
        hi = (pred <= 1) ? 2'b00 : (pred == 2) ? 2'b10 : 2'b11;
        lo = (pred == 1) ? 1'b1 : (w == 3);
        return {hi, 2'(w), 5'b00011, lo};
    endfunction

    function automatic logic [31:0] word(logic [5:0] prim, logic [4:0] d, logic rc, logic [9:0] xo);
        return {prim, d, 5'd3, 5'd9, rc, xo};
    endfunction

    task automatic send(logic [31:0] instr, logic legal, int pred, int w,
                        logic [127:0] a, logic [127:0] b, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = instr;
        in_src_a = a;
        in_src_b = b;
        e.v   = legal;
        e.ill = !legal;
        e.fv  = legal && instr[10];
        e.m   = legal ? model(pred, 8 << w, a, b) : '0;
        e.d   = instr[25:21];
        if (e.fv) held_flags = {&e.m, 1'b0, ~|e.m, 1'b0};
        e.f   = held_flags;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic op(int pred, int w, logic rc, logic [4:0] d,
                      logic [127:0] a, logic [127:0] b, string tag);
        send(word(6'b000100, d, rc, xo_of(pred, w)), 1'b1, pred, w, a, b, tag);
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        in_instr = $urandom;
        e.v = 0; e.ill = 0; e.fv = 0; e.m = '0; e.d = '0;
        e.f = held_flags;
        e.tag = "R10";
        sb.push_back(e);
    endtask

    // Monitor: one scoreboard entry per clock, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "out_valid", 128'(out_valid), 128'(e.v));
                cmp(e.ill ? e.tag : "R9", "out_illegal", 128'(out_illegal), 128'(e.ill));
                cmp(e.fv ? "R7" : "R8", "out_flag_valid", 128'(out_flag_valid), 128'(e.fv));
                cmp(e.fv ? "R7" : "R8", "out_flags", 128'(out_flags), 128'(e.f));
                if (e.v) begin
                    cmp({e.tag, "/R2"}, "out_mask", out_mask, e.m);
                    cmp("R1", "out_dest", 128'(out_dest), 128'(e.d));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        void'($urandom(32'h5eed));
        in_valid = 1'b1;
        in_instr = word(6'b000100, 5'd1, 1'b1, xo_of(0, 0));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset clears outputs even with in_valid high
        cmp("R10", "out_valid", 128'(out_valid), 128'(0));
        cmp("R10", "out_illegal", 128'(out_illegal), 128'(0));
        cmp("R10", "out_flag_valid", 128'(out_flag_valid), 128'(0));
        cmp("R10", "out_flags", 128'(out_flags), 128'(0));
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        idle();

        a = 128'h0123456789abcdef_fedcba9876543210;
        // R3 / R7: all lanes equal, recorded -> all-true
        op(0, 0, 1, 5'd4, a, a, "R3");
        // R4 / R7: inequality on equal data -> none-true
        op(1, 1, 1, 5'd5, a, a, "R4");
        // R5 / R6: sign bit difference in byte lanes
        op(2, 0, 1, 5'd6, {16{8'h80}}, {16{8'h7f}}, "R5");
        op(3, 0, 1, 5'd7, {16{8'h80}}, {16{8'h7f}}, "R6");
        // R5 / R6: 64-bit lanes, -1 vs 0
        op(2, 3, 1, 5'd8, '1, '0, "R5");
        op(3, 3, 1, 5'd9, '1, '0, "R6");
        // R2: one byte differs inside a 32-bit lane; mixed result, flags both clear
        b = a;
        b[43:40] = ~b[43:40];
        op(0, 2, 1, 5'd10, a, b, "R2");
        op(1, 2, 0, 5'd11, a, b, "R4");
        // R8: non-recorded ops leave flags as set above
        op(3, 1, 0, 5'd12, {8{16'h8000}}, {8{16'h0001}}, "R8");
        idle();
        // R9: wrong primary opcode, then unlisted extended opcodes
        send(word(6'b000101, 5'd13, 1'b1, xo_of(0, 0)), 1'b0, 0, 0, a, a, "R9");
        send(word(6'b000100, 5'd13, 1'b1, 10'b0011000110), 1'b0, 0, 0, a, a, "R9");
        send(word(6'b000100, 5'd13, 1'b1, 10'b0100000110), 1'b0, 0, 0, a, a, "R9");
        send(word(6'b000100, 5'd13, 1'b1, 10'b1000000111), 1'b0, 0, 0, a, a, "R9");
        send(word(6'b000100, 5'd13, 1'b1, 10'b1111000110), 1'b0, 0, 0, a, a, "R9");
        send(word(6'b000100, 5'd13, 1'b1, 10'b0000010110), 1'b0, 0, 0, a, a, "R9");
        idle();
        // R3: equality at every width with 64-bit lane isolation
        for (int w = 0; w < 4; w++) op(0, w, 1, 5'(w), a, a ^ 128'h1, "R3");

        // Mixed traffic: all predicates and widths, sparse lane differences
        for (int k = 0; k < 400; k++) begin
            int p;
            int w;
            string t;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = a;
            for (int j = 0; j < 16; j++) begin
                case ($urandom % 4)
                    1: b[j*8 +: 8] = 8'($urandom);
                    2: b[j*8+7] = ~b[j*8+7];
                    default: ;
                endcase
            end
            if (k % 17 == 0) b = a;
            p = $urandom % 4;
            w = $urandom % 4;
            if (p == 1 && w == 3) w = 2;
            t = (p == 0) ? "R3" : (p == 1) ? "R4" : (p == 2) ? "R5" : "R6";
            if (k % 9 == 0) idle();
            op(p, w, 1'($urandom), 5'($urandom), a, b, t);
        end
        idle();
        idle();
        while (sb.size() > 0) @(posedge clk);
        #2;
        finish_run();
    end

endmodule